// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five request sources gets serviced next. The sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port, where the serial source is the OR of receive and transmit. Software programs an enable register and a level register. The controller then picks one pending, enabled request and raises a request to the core together with a fixed vector address. The core acknowledges at an instruction boundary. A return strobe ends the routine that is running.

There are two levels, low and high. A high-level request may interrupt a running low-level routine. A request at the same level as the running routine waits until that routine returns. When several enabled requests are pending, the high level wins first. Inside a level, a fixed source order breaks the tie. Two in-service bits record which levels are active. On acknowledge of a timer source, the controller sends a one-cycle pulse so the timer flag can be cleared.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq_req`, `irq_vec` and `flag_clr` are all zero, and both register read ports return zero.
- R2: The enable register reads back its global-enable bit at bit 7 and the source enables at bits 4..0, with bits 6..5 reading 0. The level register reads back bits 4..0, with bits 7..5 reading 0. Index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1 and 4 is serial. This order is the same in `src_flag`, in both registers and in `flag_clr`.
- R3: While the global-enable bit is 0, no request is raised, whatever the source flags and source enables are.
- R4: A source whose enable bit is 0 never wins.
- R5: Among pending requests of one level, the lowest index wins. The vector is 0x0003 + 8*index, so the five vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R6: A pending level-1 request (level bit = 1) wins over any pending level-0 request.
- R7: While a level-0 routine is in service, a level-1 request is raised and other level-0 requests are held back.
- R8: While a level-1 routine is in service, no request is raised.
- R9: A return strobe clears only the highest in-service level that is set.
- R10: Once `irq_req` is high, it stays high and `irq_vec` stays unchanged until `ack`. An `ack` while `irq_req` is low has no effect.
- R11: An `ack` taken for a timer source (index 1 or 3) gives a single-cycle `flag_clr` pulse on that source's bit in the cycle after the acknowledge edge. An `ack` taken for the other sources gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | NSRC | Raw request flags, one per source |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | REG_W | Enable register write data |
| pri_wr | input | 1 | Write strobe for the level register |
| pri_wdata | input | REG_W | Level register write data |
| ack | input | 1 | Core accepts the pending request at an instruction boundary |
| reti | input | 1 | Return-from-routine strobe |
| irq_req | output | 1 | Request to the core, registered |
| irq_vec | output | VEC_W | Vector address of the presented request |
| flag_clr | output | NSRC | One-cycle clear pulse for a timer flag |
| en_rdata | output | REG_W | Enable register read value |
| pri_rdata | output | REG_W | Level register read value |

## Verification
The bench builds the controller with its default parameters: five sources, 8-bit registers, 16-bit vectors, base 3 and stride 8. With these values every vector can be compared against the absolute address the core expects. They also make both unimplemented gaps in the register read values visible, and they place the timer sources at indices 1 and 3, where the clear mask has to hit them. Nested sequences drive both in-service bits at once, so blocking and the order of returns are exercised on real level combinations.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_NSRC       = 5;
  localparam int DEF_REG_W      = 8;
  localparam int DEF_VEC_W      = 16;
  localparam int DEF_VEC_BASE   = 3;
  localparam int DEF_VEC_STRIDE = 8;

  // vector address of a source: fixed base plus a constant spacing per index
  function automatic int vec_addr(int idx, int base, int stride);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NSRC  = irq_pkg::DEF_NSRC,
  parameter int REG_W = irq_pkg::DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             pri_wr,
  input  logic [REG_W-1:0] pri_wdata,
  output logic             ea,
  output logic [NSRC-1:0]  en_src,
  output logic [NSRC-1:0]  pri_src,
  output logic [REG_W-1:0] en_rdata,
  output logic [REG_W-1:0] pri_rdata
);
  localparam int EA_BIT  = REG_W - 1;
  localparam int EN_GAP  = REG_W - 1 - NSRC;
  localparam int PRI_GAP = REG_W - NSRC;

  logic unused_wbits;
  assign unused_wbits = ^{en_wdata[EA_BIT-1:NSRC], pri_wdata[REG_W-1:NSRC]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ea      <= 1'b0;
      en_src  <= '0;
      pri_src <= '0;
    end else begin
      if (en_wr) begin
        ea     <= en_wdata[EA_BIT];
        en_src <= en_wdata[NSRC-1:0];
      end
      if (pri_wr) pri_src <= pri_wdata[NSRC-1:0];
    end
  end

  assign en_rdata  = {ea, {EN_GAP{1'b0}}, en_src};
  assign pri_rdata = {{PRI_GAP{1'b0}}, pri_src};

  // R2: the global enable bit follows the last write
  a_r2_ea_follows: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (ea == $past(en_wdata[EA_BIT])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = irq_pkg::DEF_NSRC,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  flags,
  input  logic [NSRC-1:0]  en_src,
  input  logic             ea,
  input  logic [NSRC-1:0]  pri_src,
  input  logic [1:0]       isr,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_lvl
);
  logic [NSRC-1:0] pend, hi_set, lo_set, cand, grant;
  logic [NSRC:0]   seen;
  logic            use_hi, allow_lo;

  assign pend     = flags & en_src & {NSRC{ea}};
  assign hi_set   = pend & pri_src;
  assign lo_set   = pend & ~pri_src;
  assign use_hi   = !isr[1] && (|hi_set);
  assign allow_lo = !isr[1] && !isr[0];
  assign cand     = use_hi ? hi_set : (allow_lo ? lo_set : '0);

  // fixed polling chain: the lowest index in the chosen level is granted
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign grant[g]  = cand[g] & ~seen[g];
    assign seen[g+1] = seen[g] | cand[g];
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) win_idx = win_idx | IDX_W'(i);
  end

  assign found   = seen[NSRC];
  assign win_lvl = use_hi;

  // R5: at most one source granted
  a_r5_one_grant: assert final ($onehot0(grant));
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_en,
  input  logic       set_lvl,
  input  logic       ret,
  output logic [1:0] isr
);
  logic [1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr;
    if (ret) begin
      if (isr_nxt[1]) isr_nxt[1] = 1'b0;
      else            isr_nxt[0] = 1'b0;
    end
    if (set_en) isr_nxt[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= 2'b00;
    else     isr <= isr_nxt;
  end

  // R9: a return drops the high level first and leaves the low level alone
  a_r9_ret_top: assert property (@(posedge clk) disable iff (rst)
    (ret && !set_en && isr[1]) |=> (!isr[1] && isr[0] == $past(isr[0])));
  a_r9_ret_low: assert property (@(posedge clk) disable iff (rst)
    (ret && !set_en && isr == 2'b01) |=> (isr == 2'b00));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NSRC       = irq_pkg::DEF_NSRC,
  parameter int REG_W      = irq_pkg::DEF_REG_W,
  parameter int VEC_W      = irq_pkg::DEF_VEC_W,
  parameter int VEC_BASE   = irq_pkg::DEF_VEC_BASE,
  parameter int VEC_STRIDE = irq_pkg::DEF_VEC_STRIDE,
  parameter logic [NSRC-1:0] TIMER_MASK = 5'b01010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_flag,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             pri_wr,
  input  logic [REG_W-1:0] pri_wdata,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [NSRC-1:0]  flag_clr,
  output logic [REG_W-1:0] en_rdata,
  output logic [REG_W-1:0] pri_rdata
);
  localparam int IDX_W = $clog2(NSRC);

  logic             ea;
  logic [NSRC-1:0]  en_src, pri_src;
  logic [1:0]       isr;
  logic             found, win_lvl, take, lvl_q;
  logic [IDX_W-1:0] win_idx, idx_q;

  irq_regs #(.NSRC(NSRC), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .pri_wr(pri_wr), .pri_wdata(pri_wdata), .ea(ea), .en_src(en_src),
    .pri_src(pri_src), .en_rdata(en_rdata), .pri_rdata(pri_rdata)
  );

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .flags(src_flag), .en_src(en_src), .ea(ea), .pri_src(pri_src),
    .isr(isr), .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_inservice u_isr (
    .clk(clk), .rst(rst), .set_en(take), .set_lvl(lvl_q), .ret(reti), .isr(isr)
  );

  assign take = ack && irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      idx_q    <= '0;
      lvl_q    <= 1'b0;
      flag_clr <= '0;
    end else begin
      flag_clr <= take ? (TIMER_MASK & (NSRC'(1) << idx_q)) : '0;
      if (take) begin
        irq_req <= 1'b0;
      end else if (!irq_req && found) begin
        irq_req <= 1'b1;
        idx_q   <= win_idx;
        lvl_q   <= win_lvl;
        irq_vec <= VEC_W'(irq_pkg::vec_addr(int'(win_idx), VEC_BASE, VEC_STRIDE));
      end
    end
  end

  // R10: request and vector hold until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec)));
  // R8: nothing presented while the high level is in service
  a_r8_block: assert property (@(posedge clk) disable iff (rst)
    isr[1] |-> !irq_req);
  // R3: a new request needs the global enable in the cycle before
  a_r3_global: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(ea));
  // R11: clear pulses only follow a taken acknowledge, only for timers
  a_r11_clr_cause: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |-> $past(ack && irq_req));
  a_r11_clr_shape: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr) && ((flag_clr & ~TIMER_MASK) == '0));
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/100ps
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src_flag = '0;
  logic        en_wr = 1'b0, pri_wr = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [7:0]  en_wdata = '0, pri_wdata = '0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [4:0]  flag_clr;
  logic [7:0]  en_rdata, pri_rdata;

  always #2 clk = ~clk;

  irq_ctrl u0 (
    .clk(clk), .rst(rst), .src_flag(src_flag), .en_wr(en_wr), .en_wdata(en_wdata),
    .pri_wr(pri_wr), .pri_wdata(pri_wdata), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr),
    .en_rdata(en_rdata), .pri_rdata(pri_rdata)
  );

  typedef struct {
    string       tag;
    int          kind;
    logic [15:0] val;
  } item_t;

  item_t sb[$];
  event  smp_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  // monitor: pops expected items and compares them with the outputs
  always @(smp_ev) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {15'd0, irq_req};
        1: act = irq_vec;
        2: act = {11'd0, flag_clr};
        3: act = {8'd0, en_rdata};
        default: act = {8'd0, pri_rdata};
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic push(string tag, int kind, logic [15:0] val);
    item_t it;
    it.tag = tag; it.kind = kind; it.val = val;
    sb.push_back(it);
  endtask

  task automatic sample();
    -> smp_ev;
    #0;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_en(logic [7:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_pri(logic [7:0] v);
    @(negedge clk); pri_wr = 1'b1; pri_wdata = v;
    @(negedge clk); pri_wr = 1'b0;
  endtask

  task automatic set_flags(logic [4:0] v);
    @(negedge clk); src_flag = v;
  endtask

  task automatic expect_req(string tag, logic [15:0] vec);
    push(tag, 0, 16'd1);
    push(tag, 1, vec);
    sample();
  endtask

  task automatic expect_idle(string tag);
    push(tag, 0, 16'd0);
    sample();
  endtask

  // acknowledge the pending request, check the clear pulse and its length
  task automatic service(string tag, logic [4:0] clr);
    @(negedge clk); ack = 1'b1;
    @(posedge clk); #1;
    push(tag, 2, {11'd0, clr});
    push(tag, 0, 16'd0);
    sample();
    @(negedge clk); ack = 1'b0;
    tick(1);
    push(tag, 2, 16'd0);
    sample();
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    @(negedge clk); rst = 1'b0;
    tick(1);
    // R1 reset state
    push("R1", 0, 16'd0); push("R1", 1, 16'd0); push("R1", 2, 16'd0);
    push("R1", 3, 16'd0); push("R1", 4, 16'd0);
    sample();

    // R2 readback with unimplemented bits
    wr_en(8'hFF); wr_pri(8'hFF); tick(1);
    push("R2", 3, 16'h009F); push("R2", 4, 16'h001F);
    sample();
    wr_pri(8'h00);

    // R3 global enable off
    wr_en(8'h1F); set_flags(5'h1F); tick(3);
    expect_idle("R3");

    // R4 only timer 1 enabled
    wr_en(8'h88); tick(2);
    expect_req("R4", 16'h001B);
    service("R4_R11", 5'b01000);
    set_flags(5'h00); ret(); tick(1);

    // R5 ordering within level 0
    wr_en(8'h9F);
    set_flags(5'h1E); tick(2);
    expect_req("R5", 16'h000B);
    service("R5_R11", 5'b00010);
    set_flags(5'h00); ret();
    set_flags(5'h14); tick(2);
    expect_req("R5", 16'h0013);
    service("R5_R11", 5'b00000);
    set_flags(5'h00); ret();
    set_flags(5'h10); tick(2);
    expect_req("R5", 16'h0023);
    service("R11_serial", 5'b00000);
    set_flags(5'h00); ret();

    // R6 level 1 beats level 0
    wr_pri(8'h10); set_flags(5'h1F); tick(2);
    expect_req("R6", 16'h0023);
    service("R6", 5'b00000);
    set_flags(5'h00); ret(); wr_pri(8'h00);

    // R7 / R8 / R9 nesting with timer 1 at level 1
    wr_pri(8'h08);
    set_flags(5'h01); tick(2);
    expect_req("R7", 16'h0003);
    service("R7", 5'b00000);
    set_flags(5'h03); tick(3);
    expect_idle("R7_same_level");
    set_flags(5'h0B); tick(2);
    expect_req("R7_preempt", 16'h001B);
    service("R7_R11", 5'b01000);
    set_flags(5'h1F); tick(3);
    expect_idle("R8");
    set_flags(5'h03); ret(); tick(3);
    expect_idle("R9_low_kept");
    ret(); tick(2);
    expect_req("R9", 16'h0003);
    service("R9", 5'b00000);
    set_flags(5'h00); ret(); wr_pri(8'h00);

    // R10 hold until acknowledge
    set_flags(5'h08); tick(2);
    expect_req("R10", 16'h001B);
    set_flags(5'h09); tick(3);
    expect_req("R10_hold", 16'h001B);
    service("R10", 5'b01000);
    set_flags(5'h00); ret(); tick(1);

    // R10 stray acknowledge ignored
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    tick(1);
    push("R10_stray", 2, 16'd0);
    sample();
    set_flags(5'h01); tick(2);
    expect_req("R10_stray", 16'h0003);
    service("R10_stray", 5'b00000);
    set_flags(5'h00); ret();

    tick(1);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule